// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block sits between a host register port and the card-side command engine of an SD host controller. A host write to the command register is decoded into an index, a response type, a busy-wait flag, a command class and a data direction. The block issues the command to the card side with a one-cycle request strobe and then waits. When the card side returns a response-valid strobe with a byte count and up to sixteen response bytes, the block checks the byte count against the expected response type. It packs the bytes into eight readable 16-bit words and folds the outcome into a status register.

The status register is write-one-to-clear. A level interrupt is raised whenever a status bit is set and its bit in the interrupt-enable mask is also set. A controller enable bit gates all command issue. One special form of command completes on the spot with no card exchange. CRC handling, serial bit timing and the data path are outside this block.

Register map (word addresses): 0 command (read returns the last accepted command word), 1 control (bit 0 = enable), 2 status, 3 interrupt mask, 8 to 15 response words 0 to 7. Other addresses read as zero and ignore writes.

Top module: `sdcmd_resp_unit`

## Requirements
- R1: A command write that is accepted (enable set, block not busy) drives `card_req` high for exactly the next cycle. During that cycle it presents index = bits 5:0, direction = bit 15 and command class = bits 13:12 of the written word. `busy` rises with `card_req` and stays high until the cycle after the response-valid strobe. Command writes made while `busy` is high are ignored.
- R2: While control bit 0 is 0, a command write is ignored. No request is made, `busy` stays low and the command readback is unchanged.
- R3: An accepted command clears all eight response words before the response arrives.
- R4: A command word with the init flag (bit 7) set and index 0 sets status bit 0 (end of command) at once. It makes no card request and does not raise `busy`.
- R5: The response type is bits 10:8 (0 none, 1 R1, 2 R2, 3 R3, 6 R6; codes 4, 5 and 7 behave as none). An R1 command with the busy flag (bit 11) set is issued as R1b, with `card_wait_busy` high, and is otherwise evaluated as R1.
- R6: R1, R1b, R3 and R6 need at least 4 response bytes, and R2 needs 16. With fewer bytes, status bit 7 (timeout) is set, bit 0 is not set and no response word is stored.
- R7: When a response of a known type is long enough, byte pair k (byte 2k high, byte 2k+1 low) is stored in response word 7-k. Byte k arrives at `card_rsp_data[8k+7:8k]`. The none type stores nothing.
- R8: For R1/R1b, the 32-bit card status {byte0, byte1, byte2, byte3} is ANDed with 0xFDF90000. For R6, the 16-bit value {byte2, byte3} is ANDed with 0xE008. A nonzero result sets status bit 14 (card error). Any other completed exchange clears bit 14.
- R9: For a valid R3 response, byte0 bit 7 (OCR bit 31) set clears status bits 12:0 before the completion bit is applied. If it is clear, status bit 12 (card busy) is set.
- R10: A completed exchange without timeout sets status bits 0 and 2 when the index is 12, and only bit 0 for any other index.
- R11: Writing ones to the status register clears those bits, and status bit 15 always reads 0. The mask register keeps bits 14:0 only. `irq` is high exactly when some status bit and its mask bit are both set.
- R12: After reset, status, mask, control, command readback and all response words are zero, and `busy`, `card_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (write and read) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| card_req | output | 1 | One-cycle command issue strobe |
| card_idx | output | 6 | Command index of the issued command |
| card_dir | output | 1 | Data direction of the issued command |
| card_ctype | output | 2 | Command class of the issued command |
| card_wait_busy | output | 1 | Issued command expects a busy phase (R1b) |
| card_rsp_valid | input | 1 | Response available strobe |
| card_rsp_len | input | 5 | Number of response bytes received (0 to 16) |
| card_rsp_data | input | 128 | Response bytes, byte k in bits 8k+7:8k |
| busy | output | 1 | Command issued and response not yet processed |
| irq | output | 1 | Level interrupt, OR of status AND mask |

## Verification
The bench builds the block with its default parameters: a 4-bit register address and the standard R1 and R6 error masks. With these values the whole map fits in sixteen words, so every one of the eight response words can be read back directly. The masks put both sides of the card-error decision in reach: a high status byte that hits the R1 mask, a harmless status word, an R6 value with bit 13 set and one without it. Short and full byte counts cover the timeout boundary of each length class.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_W     = 16;
  localparam int STAT_W    = 16;
  localparam int MASK_W    = STAT_W - 1;
  localparam int RSP_WORDS = 8;
  localparam int RSP_BYTES = 2 * RSP_WORDS;
  localparam int RSP_DW    = 8 * RSP_BYTES;
  localparam int LEN_W     = $clog2(RSP_BYTES + 1);
  localparam int IDX_W     = 6;

  // response type codes as carried in the command word
  localparam logic [2:0] RT_NONE = 3'd0;
  localparam logic [2:0] RT_R1   = 3'd1;
  localparam logic [2:0] RT_R2   = 3'd2;
  localparam logic [2:0] RT_R3   = 3'd3;
  localparam logic [2:0] RT_R6   = 3'd6;

  // status bit positions
  localparam int ST_DONE  = 0;
  localparam int ST_STOP  = 2;
  localparam int ST_TMO   = 7;
  localparam int ST_CBUSY = 12;
  localparam int ST_CERR  = 14;

  localparam logic [IDX_W-1:0] IDX_STOP = 6'd12;

  typedef struct packed {
    logic             dir;
    logic             rsvd14;
    logic [1:0]       ctype;
    logic             bflag;
    logic [2:0]       rtype;
    logic             init;
    logic             rsvd6;
    logic [IDX_W-1:0] idx;
  } cmd_word_t;
endpackage

// File: rtl/sdc_rst_sync.sv
module sdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
  import sdc_pkg::*;
(
  input  logic [CMD_W-1:0] raw,
  output logic [IDX_W-1:0] idx,
  output logic             dir,
  output logic [1:0]       ctype,
  output logic [2:0]       rtype,
  output logic             wait_busy,
  output logic             init0
);
  cmd_word_t c;
  logic      unused_rsvd;

  assign c           = cmd_word_t'(raw);
  assign idx         = c.idx;
  assign dir         = c.dir;
  assign ctype       = c.ctype;
  assign rtype       = c.rtype;
  // an R1 with the busy flag becomes R1b: same checks, busy phase expected
  assign wait_busy   = (c.rtype == RT_R1) && c.bflag;
  assign init0       = c.init && (c.idx == '0);
  assign unused_rsvd = c.rsvd14 ^ c.rsvd6;
endmodule

// File: rtl/sdc_resp_eval.sv
module sdc_resp_eval
  import sdc_pkg::*;
#(
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE008
) (
  input  logic [2:0]        rtype,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  input  logic [31:0]       head,     // bytes 0..3, byte k at [8k+7:8k]
  output logic [STAT_W-1:0] st_set,
  output logic [STAT_W-1:0] st_clr,
  output logic              store
);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(RSP_BYTES);

  logic [31:0]      r1_word;
  logic [15:0]      r6_word;
  logic             known;
  logic [LEN_W-1:0] need;
  logic             timeout;
  logic             err;

  assign r1_word = {head[7:0], head[15:8], head[23:16], head[31:24]};
  assign r6_word = {head[23:16], head[31:24]};

  always_comb begin
    known = 1'b0;
    need  = '0;
    case (rtype)
      RT_R1, RT_R3, RT_R6: begin known = 1'b1; need = LEN_SHORT; end
      RT_R2:               begin known = 1'b1; need = LEN_LONG;  end
      default:             begin known = 1'b0; need = '0;        end
    endcase
  end

  assign timeout = known && (len < need);
  assign store   = known && !timeout;

  always_comb begin
    err = 1'b0;
    if (!timeout) begin
      if (rtype == RT_R1) err = |(r1_word & R1_ERR_MASK);
      if (rtype == RT_R6) err = |(r6_word & R6_ERR_MASK);
    end
  end

  always_comb begin
    st_set = '0;
    st_clr = '0;
    if ((rtype == RT_R3) && !timeout) begin
      if (r1_word[31]) st_clr[ST_CBUSY:0] = '1;
      else             st_set[ST_CBUSY]   = 1'b1;
    end
    if (err) st_set[ST_CERR] = 1'b1;
    else     st_clr[ST_CERR] = 1'b1;
    if (timeout) begin
      st_set[ST_TMO] = 1'b1;
    end else begin
      st_set[ST_DONE] = 1'b1;
      if (idx == IDX_STOP) st_set[ST_STOP] = 1'b1;
    end
  end
endmodule

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store
  import sdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [RSP_DW-1:0] data,
  output logic [15:0]       words [RSP_WORDS]
);
  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
    localparam int PAIR = RSP_WORDS - 1 - w;
    logic [15:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= {data[8*(2*PAIR) +: 8], data[8*(2*PAIR+1) +: 8]};
      else if (clr)  word_q <= '0;
    end

    assign words[w] = word_q;
  end
endmodule

// File: rtl/sdcmd_resp_unit.sv
module sdcmd_resp_unit
  import sdc_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CMD_W-1:0]  reg_wdata,
  output logic [CMD_W-1:0]  reg_rdata,
  output logic              card_req,
  output logic [IDX_W-1:0]  card_idx,
  output logic              card_dir,
  output logic [1:0]        card_ctype,
  output logic              card_wait_busy,
  input  logic              card_rsp_valid,
  input  logic [LEN_W-1:0]  card_rsp_len,
  input  logic [RSP_DW-1:0] card_rsp_data,
  output logic              busy,
  output logic              irq
);
  localparam int              WSEL_W   = $clog2(RSP_WORDS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RSP  = ADDR_W'(RSP_WORDS);

  logic rst_n_s;

  sdc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  // decode of the incoming command word
  logic [IDX_W-1:0] dec_idx;
  logic             dec_dir;
  logic [1:0]       dec_ctype;
  logic [2:0]       dec_rtype;
  logic             dec_wait_busy;
  logic             dec_init0;

  sdc_cmd_decode u_dec (
    .raw(reg_wdata), .idx(dec_idx), .dir(dec_dir), .ctype(dec_ctype),
    .rtype(dec_rtype), .wait_busy(dec_wait_busy), .init0(dec_init0)
  );

  // architectural state
  logic              ctrl_en_q;
  logic [CMD_W-1:0]  last_cmd_q;
  logic [STAT_W-1:0] status_q, status_d;
  logic [MASK_W-1:0] mask_q;
  logic              busy_q, busy_d;
  logic              req_q;
  logic [IDX_W-1:0]  idx_q;
  logic              dir_q;
  logic [1:0]        ctype_q;
  logic              wb_q;
  logic [2:0]        rtype_q;

  // strobes
  logic wr_cmd, wr_ctrl, wr_stat, wr_mask;
  logic cmd_take, issue, rsp_done, st_en;

  assign wr_cmd   = reg_wr && (reg_addr == A_CMD);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign wr_mask  = reg_wr && (reg_addr == A_MASK);
  assign cmd_take = wr_cmd && ctrl_en_q && !busy_q;
  assign issue    = cmd_take && !dec_init0;
  assign rsp_done = busy_q && card_rsp_valid;

  // response evaluation against the type latched at issue
  logic [STAT_W-1:0] ev_set, ev_clr;
  logic              ev_store;

  sdc_resp_eval #(.R1_ERR_MASK(R1_ERR_MASK), .R6_ERR_MASK(R6_ERR_MASK)) u_eval (
    .rtype(rtype_q), .idx(idx_q), .len(card_rsp_len),
    .head(card_rsp_data[31:0]),
    .st_set(ev_set), .st_clr(ev_clr), .store(ev_store)
  );

  logic [15:0] words [RSP_WORDS];

  sdc_rsp_store u_store (
    .clk(clk), .rst_n(rst_n_s), .clr(cmd_take), .load(rsp_done && ev_store),
    .data(card_rsp_data), .words(words)
  );

  // next state
  always_comb begin
    status_d = status_q;
    if (wr_stat)               status_d = status_d & ~reg_wdata;
    if (cmd_take && dec_init0) status_d[ST_DONE] = 1'b1;
    if (rsp_done)              status_d = (status_d & ~ev_clr) | ev_set;
    status_d[STAT_W-1] = 1'b0;
  end

  assign st_en = wr_stat || cmd_take || rsp_done;

  always_comb begin
    busy_d = busy_q;
    if (issue)         busy_d = 1'b1;
    else if (rsp_done) busy_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_en_q  <= 1'b0;
      last_cmd_q <= '0;
      status_q   <= '0;
      mask_q     <= '0;
      busy_q     <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      req_q  <= issue;
      busy_q <= busy_d;
      if (wr_ctrl)  ctrl_en_q  <= reg_wdata[0];
      if (cmd_take) last_cmd_q <= reg_wdata;
      if (st_en)    status_q   <= status_d;
      if (wr_mask)  mask_q     <= reg_wdata[MASK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q   <= '0;
      dir_q   <= 1'b0;
      ctype_q <= '0;
      wb_q    <= 1'b0;
      rtype_q <= RT_NONE;
    end else if (issue) begin
      idx_q   <= dec_idx;
      dir_q   <= dec_dir;
      ctype_q <= dec_ctype;
      wb_q    <= dec_wait_busy;
      rtype_q <= dec_rtype;
    end
  end

  // read port
  always_comb begin
    reg_rdata = '0;
    if (reg_addr >= A_RSP) begin
      reg_rdata = words[reg_addr[WSEL_W-1:0]];
    end else begin
      case (reg_addr)
        A_CMD:   reg_rdata = last_cmd_q;
        A_CTRL:  reg_rdata = {{(CMD_W-1){1'b0}}, ctrl_en_q};
        A_STAT:  reg_rdata = status_q;
        A_MASK:  reg_rdata = {1'b0, mask_q};
        default: reg_rdata = '0;
      endcase
    end
  end

  assign card_req       = req_q;
  assign card_idx       = idx_q;
  assign card_dir       = dir_q;
  assign card_ctype     = ctype_q;
  assign card_wait_busy = wb_q;
  assign busy           = busy_q;
  assign irq            = |(status_q[MASK_W-1:0] & mask_q);
endmodule

// File: rtl/sdcmd_resp_chk.sv
module sdcmd_resp_chk
  import sdc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CMD_W-1:0]  reg_wdata,
  input logic              card_req,
  input logic              card_rsp_valid,
  input logic [LEN_W-1:0]  card_rsp_len,
  input logic              busy,
  input logic              irq,
  input logic [STAT_W-1:0] status_q,
  input logic              ctrl_en_q,
  input logic [2:0]        rtype_q
);
  // R2: command writes with the enable bit low leave the card side idle
  assert_off_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && !ctrl_en_q && !busy) |=> (!card_req && !busy));

  // R1: a request is only ever made inside a busy window
  assert_req_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |-> busy);

  // R1: the response strobe ends the busy window
  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && card_rsp_valid) |=> !busy);

  // R4: init flag with index 0 completes without a card exchange
  assert_init0_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && ctrl_en_q && !busy &&
     reg_wdata[7] && reg_wdata[5:0] == 6'd0) |=> (!card_req && !busy && status_q[0]));

  // R6: a short R2 response flags a timeout
  assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && card_rsp_valid && rtype_q == RT_R2 && card_rsp_len < LEN_W'(RSP_BYTES))
    |=> status_q[ST_TMO]);

  // R11: clearing every status bit silences the interrupt
  assert_w1c_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2) && reg_wdata == 16'hFFFF && !(busy && card_rsp_valid))
    |=> (!irq && status_q == '0));

  // R11: the top status bit never sets
  assert_top_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[STAT_W-1]);
endmodule

bind sdcmd_resp_unit sdcmd_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .card_req(card_req), .card_rsp_valid(card_rsp_valid),
  .card_rsp_len(card_rsp_len), .busy(busy), .irq(irq), .status_q(status_q),
  .ctrl_en_q(ctrl_en_q), .rtype_q(rtype_q)
);

// File: tb/tb_sdcmd_resp_unit.sv
module tb_sdcmd_resp_unit;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CMD = 4'd0, A_CTRL = 4'd1, A_STAT = 4'd2, A_MASK = 4'd3, A_RSP = 4'd8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [15:0]  reg_wdata = '0;
  logic [15:0]  reg_rdata;
  logic         card_req, card_dir, card_wait_busy, busy, irq;
  logic [5:0]   card_idx;
  logic [1:0]   card_ctype;
  logic         card_rsp_valid = 1'b0;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] cur_st = '0;
  logic [143:0] exp_q[$];
  string        tag_q[$];
  logic         mon_busy = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sdcmd_resp_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_req(card_req),
    .card_idx(card_idx), .card_dir(card_dir), .card_ctype(card_ctype),
    .card_wait_busy(card_wait_busy), .card_rsp_valid(card_rsp_valid),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
    .busy(busy), .irq(irq)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // response bytes: byte0..3 carry st32 most significant first, the rest a ramp
  function automatic logic [127:0] mk(input logic [7:0] seed, input logic [31:0] st32);
    logic [127:0] d;
    for (int k = 0; k < 16; k++) d[8*k +: 8] = seed + 8'(k * 17);
    d[7:0] = st32[31:24]; d[15:8] = st32[23:16]; d[23:16] = st32[15:8]; d[31:24] = st32[7:0];
    return d;
  endfunction

  function automatic logic known_type(input logic [2:0] rt);
    return (rt == 3'd1) || (rt == 3'd2) || (rt == 3'd3) || (rt == 3'd6);
  endfunction

  function automatic logic is_to(input logic [15:0] cmd, input logic [4:0] len);
    logic [4:0] need;
    need = (cmd[10:8] == 3'd2) ? 5'd16 : 5'd4;
    return known_type(cmd[10:8]) && (len < need);
  endfunction

  // expected status per R6, R8, R9, R10
  function automatic logic [15:0] model_st(input logic [15:0] cur, input logic [15:0] cmd,
                                           input logic [4:0] len, input logic [127:0] d);
    logic [15:0] s;
    logic [31:0] cs;
    logic to, e;
    s  = cur;
    to = is_to(cmd, len);
    cs = {d[7:0], d[15:8], d[23:16], d[31:24]};
    if (!to && cmd[10:8] == 3'd3) begin
      if (cs[31]) s = s & 16'hE000;
      else        s = s | 16'h1000;
    end
    e = !to && ((cmd[10:8] == 3'd1 && (cs & 32'hFDF9_0000) != 0) ||
                (cmd[10:8] == 3'd6 && (cs[15:0] & 16'hE008) != 0));
    s[14] = e;
    if (to)                    s[7] = 1'b1;
    else if (cmd[5:0] == 6'd12) s = s | 16'h0005;
    else                       s[0] = 1'b1;
    return s;
  endfunction

  // expected response words per R7
  function automatic logic [127:0] model_w(input logic [15:0] cmd, input logic [4:0] len,
                                           input logic [127:0] d);
    logic [127:0] w;
    w = '0;
    if (known_type(cmd[10:8]) && !is_to(cmd, len))
      for (int j = 0; j < 8; j++)
        w[16*j +: 16] = {d[8*(2*(7-j)) +: 8], d[8*(2*(7-j)+1) +: 8]};
    return w;
  endfunction

  task automatic push_exp(input string tag, input logic [15:0] st, input logic [127:0] w);
    exp_q.push_back({st, w});
    tag_q.push_back(tag);
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  // monitor: pops expectations and compares register contents
  initial begin
    logic [143:0] item;
    logic [15:0]  v;
    string        tg;
    forever begin
      wait (exp_q.size() != 0);
      mon_busy = 1'b1;
      item = exp_q.pop_front();
      tg   = tag_q.pop_front();
      reg_read(A_STAT, v);
      chk({tg, " status"}, 128'(v), 128'(item[143:128]));
      for (int j = 0; j < 8; j++) begin
        reg_read(A_RSP + AW'(j), v);
        chk({tg, " word"}, 128'(v), 128'(item[16*j +: 16]));
      end
      mon_busy = 1'b0;
    end
  end

  task automatic issue(input logic [15:0] cmd);
    reg_write(A_CMD, cmd);
    chk("R1 request strobe", {card_req, busy}, 2'b11);
    chk("R1 index", card_idx, cmd[5:0]);
    chk("R1 direction", card_dir, cmd[15]);
    chk("R1 class", card_ctype, cmd[13:12]);
    chk("R5 busy-wait flag", card_wait_busy, (cmd[10:8] == 3'd1) && cmd[11]);
  endtask

  task automatic respond(input string tag, input logic [15:0] cmd, input logic [4:0] len,
                         input logic [127:0] d);
    @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = d;
    @(negedge clk);
    card_rsp_valid = 1'b0;
    chk("R1 busy released", busy, 1'b0);
    cur_st = model_st(cur_st, cmd, len, d);
    push_exp(tag, cur_st, model_w(cmd, len, d));
  endtask

  task automatic run_cmd(input string tag, input logic [15:0] cmd, input logic [4:0] len,
                         input logic [127:0] d);
    issue(cmd);
    repeat (2) @(negedge clk);
    respond(tag, cmd, len, d);
  endtask

  task automatic clr_status();
    reg_write(A_STAT, 16'hFFFF);
    cur_st = '0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    chk("R12 busy/req/irq", {busy, card_req, irq}, 3'b000);
    reg_read(A_STAT, v); chk("R12 status", v, 16'h0);
    reg_read(A_MASK, v); chk("R12 mask", v, 16'h0);
    reg_read(A_RSP, v);  chk("R12 word0", v, 16'h0);

    // R2: disabled controller ignores commands
    reg_write(A_CMD, 16'h0111);
    chk("R2 no request", {card_req, busy}, 2'b00);
    @(negedge clk);
    chk("R2 still idle", {card_req, busy}, 2'b00);
    reg_read(A_CMD, v); chk("R2 readback", v, 16'h0);

    reg_write(A_CTRL, 16'h0001);

    // R1 with clean status, read direction, class 3
    run_cmd("R10 R1 ok", 16'hB111, 5'd4, mk(8'h10, 32'h0000_0900));
    // R5 R1b with an error bit: R8 card error
    run_cmd("R8 R1b err", 16'h0907, 5'd4, mk(8'h20, 32'h8000_0000));
    // R7 full R2 packing, R8 bit 14 cleared
    run_cmd("R7 R2 full", 16'h0202, 5'd16, mk(8'h31, 32'h1234_5678));

    // R3 words cleared once a command is accepted; R6 short R2
    issue(16'h0202);
    reg_read(A_RSP + 4'd7, v); chk("R3 word7 cleared", v, 16'h0);
    reg_read(A_RSP, v);        chk("R3 word0 cleared", v, 16'h0);
    respond("R6 R2 short", 16'h0202, 5'd4, mk(8'h44, 32'h0));

    // R9 OCR bit 31 set then clear
    run_cmd("R9 R3 ready", 16'h0329, 5'd4, mk(8'h50, 32'h80FF_8000));
    run_cmd("R9 R3 busy", 16'h0329, 5'd4, mk(8'h60, 32'h00FF_8000));
    // R6 also too short for R1
    run_cmd("R6 R1 short", 16'h0111, 5'd3, mk(8'h65, 32'h0));

    // R8 R6 error mask
    clr_status();
    run_cmd("R8 R6 err", 16'h0603, 5'd4, mk(8'h70, 32'h0000_2000));
    run_cmd("R8 R6 ok", 16'h0603, 5'd4, mk(8'h71, 32'hFFFF_0100));

    // R10 stop command and unused type codes
    clr_status();
    run_cmd("R10 type5", 16'h0509, 5'd16, mk(8'h80, 32'h0));
    clr_status();
    run_cmd("R10 stop", 16'h000C, 5'd0, mk(8'h90, 32'h0));

    // R11 mask width, interrupt level, write-one-to-clear
    reg_write(A_MASK, 16'hFFFF);
    reg_read(A_MASK, v); chk("R11 mask width", v, 16'h7FFF);
    chk("R11 irq on", irq, 1'b1);
    reg_write(A_MASK, 16'h0004);
    chk("R11 irq masked bit", irq, 1'b1);
    reg_write(A_STAT, 16'h0004);
    cur_st = 16'h0001;
    chk("R11 irq after clear", irq, 1'b0);
    reg_read(A_STAT, v); chk("R11 status after clear", v, 16'h0001);
    reg_write(A_MASK, 16'h0000);

    // R1 command writes during busy are ignored
    issue(16'h0111);
    reg_write(A_CMD, 16'h0105);
    chk("R1 ignored while busy", {card_req, card_idx}, {1'b0, 6'd17});
    reg_read(A_CMD, v); chk("R1 readback while busy", v, 16'h0111);
    respond("R1 after ignore", 16'h0111, 5'd4, mk(8'hA0, 32'h0));

    // R4 init with index 0
    clr_status();
    reg_write(A_CMD, 16'h0080);
    chk("R4 no request", {card_req, busy}, 2'b00);
    cur_st = 16'h0001;
    push_exp("R4 init0", cur_st, '0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule